// File: doc/BRIEF.md
# Debug Event Detector

This block watches the retired-instruction stream and the store stream of a processor core and reports debug events. It covers three event classes: a branch that was taken, the fetch of an instruction, and a write to storage. Each class counts only when the address it concerns falls inside one programmable window.

The window is given by a lower and an upper bound. When the lower bound is above the upper bound, the window wraps past the top of the address space. A three-bit class mask selects which classes are armed. A single enable bit from the status word gates all detection.

Events found in a cycle are merged into a sticky event-code vector, and an interruption request is raised. The request holds until the core acknowledges it. Priority between interruptions and the swap of the status word belong to the core and are not part of this block.

Top module: `dbg_event_watch`

## Requirements
- R1: After reset, evt_code_o is 3'b000 and irq_o is low.
- R2: A retired instruction (ret_valid_i high) with ret_br_taken_i high and ret_br_tgt_i inside the window sets evt_code_o bit 0 in the cycle after that edge. A branch that is not taken never sets bit 0.
- R3: A retired instruction whose ret_addr_i lies inside the window sets evt_code_o bit 1 in the cycle after that edge.
- R4: A store (st_valid_i high) whose st_addr_i lies inside the window sets evt_code_o bit 2. A store with st_suppress_i high never sets it.
- R5: When ctl_lo_i <= ctl_hi_i, the window is lo..hi with both bounds included. Addresses outside it produce no event.
- R6: When ctl_lo_i > ctl_hi_i, an address is inside the window if it is >= lo or <= hi (the window wraps).
- R7: Class mask ctl_mask_i bit 0 arms branch events, bit 1 arms fetch events and bit 2 arms store events. A class whose bit is clear produces no event.
- R8: With sw_enable_i low, no class produces an event.
- R9: Events of different classes in the same cycle are merged into one code vector.
- R10: Without irq_ack_i, code bits only accumulate. With irq_ack_i high, the code is replaced by the events of that same cycle alone.
- R11: irq_o is high exactly when evt_code_o is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ret_valid_i | input | 1 | A retired instruction is present this cycle |
| ret_addr_i | input | AW | Address of the retired instruction |
| ret_br_taken_i | input | 1 | The retired instruction is a taken branch |
| ret_br_tgt_i | input | AW | Target address of the branch |
| st_valid_i | input | 1 | A store is present this cycle |
| st_addr_i | input | AW | Store address |
| st_suppress_i | input | 1 | The store's access descriptor suppresses debug events |
| ctl_mask_i | input | 3 | Class mask: bit 0 branch, bit 1 fetch, bit 2 store |
| ctl_lo_i | input | AW | Window lower bound |
| ctl_hi_i | input | AW | Window upper bound |
| sw_enable_i | input | 1 | Master enable from the status word |
| irq_ack_i | input | 1 | Acknowledge of the pending request |
| evt_code_o | output | 3 | Sticky event-code vector |
| irq_o | output | 1 | Interruption request |

## Verification
The bench builds the block with AW set to 16. With that width, the last address 16'hFFFF and the wrap back to 16'h0000 can be driven directly, so a wrapped window can be tested on both sides of its seam. The bench also probes the exact edges of a plain window, one address inside and one outside each bound. Directed cycles then cover the case where an acknowledge and a new event fall in the same cycle.

// File: rtl/dbg_event_pkg.sv
package dbg_event_pkg;
  localparam int unsigned NUM_EV = 3;
  localparam int unsigned EV_BR  = 0;
  localparam int unsigned EV_IF  = 1;
  localparam int unsigned EV_ST  = 2;
  typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/dbg_range_cmp.sv
module dbg_range_cmp #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  output logic          hit_o
);
  logic above_lo, below_hi, wrap;

  always_comb begin
    above_lo = (addr_i >= lo_i);
    below_hi = (addr_i <= hi_i);
    wrap     = (lo_i > hi_i);
    hit_o    = wrap ? (above_lo | below_hi) : (above_lo & below_hi);
  end
endmodule

// File: rtl/dbg_event_qual.sv
module dbg_event_qual
  import dbg_event_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [NUM_EV-1:0][AW-1:0] ev_addr_i,
  input  ev_vec_t                   ev_req_i,
  input  ev_vec_t                   mask_i,
  input  logic                      enable_i,
  input  logic [AW-1:0]             lo_i,
  input  logic [AW-1:0]             hi_i,
  output ev_vec_t                   hit_o
);
  ev_vec_t in_win;

  for (genvar g = 0; g < NUM_EV; g++) begin : g_cls
    dbg_range_cmp #(.AW(AW)) u_cmp (
      .addr_i (ev_addr_i[g]),
      .lo_i   (lo_i),
      .hi_i   (hi_i),
      .hit_o  (in_win[g])
    );
    assign hit_o[g] = enable_i & mask_i[g] & ev_req_i[g] & in_win[g];
  end
endmodule

// File: rtl/dbg_event_hold.sv
module dbg_event_hold
  import dbg_event_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ev_vec_t hit_i,
  input  logic    ack_i,
  output ev_vec_t code_o,
  output logic    irq_o
);
  ev_vec_t code_q, code_d;
  logic    irq_q;

  always_comb code_d = ack_i ? hit_i : (code_q | hit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      irq_q  <= |code_d;
    end
  end

  assign code_o = code_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/dbg_event_watch.sv
module dbg_event_watch
  import dbg_event_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ret_valid_i,
  input  logic [AW-1:0] ret_addr_i,
  input  logic          ret_br_taken_i,
  input  logic [AW-1:0] ret_br_tgt_i,
  input  logic          st_valid_i,
  input  logic [AW-1:0] st_addr_i,
  input  logic          st_suppress_i,
  input  logic [2:0]    ctl_mask_i,
  input  logic [AW-1:0] ctl_lo_i,
  input  logic [AW-1:0] ctl_hi_i,
  input  logic          sw_enable_i,
  input  logic          irq_ack_i,
  output logic [2:0]    evt_code_o,
  output logic          irq_o
);
  logic [NUM_EV-1:0][AW-1:0] ev_addr;
  ev_vec_t ev_req, hit;

  always_comb begin
    ev_addr[EV_BR] = ret_br_tgt_i;
    ev_addr[EV_IF] = ret_addr_i;
    ev_addr[EV_ST] = st_addr_i;
    ev_req[EV_BR]  = ret_valid_i & ret_br_taken_i;
    ev_req[EV_IF]  = ret_valid_i;
    ev_req[EV_ST]  = st_valid_i & ~st_suppress_i;
  end

  dbg_event_qual #(.AW(AW)) u_qual (
    .ev_addr_i (ev_addr),
    .ev_req_i  (ev_req),
    .mask_i    (ctl_mask_i),
    .enable_i  (sw_enable_i),
    .lo_i      (ctl_lo_i),
    .hi_i      (ctl_hi_i),
    .hit_o     (hit)
  );

  dbg_event_hold u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .ack_i  (irq_ack_i),
    .code_o (evt_code_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/dbg_event_watch_chk.sv
module dbg_event_watch_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ret_valid_i,
  input logic       st_valid_i,
  input logic       st_suppress_i,
  input logic       sw_enable_i,
  input logic       irq_ack_i,
  input logic [2:0] evt_code_o,
  input logic       irq_o
);
  p_irq_code_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (evt_code_o != 3'b000));

  p_disabled_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_enable_i && !irq_o) |=> !irq_o);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_ack_i |=> ((evt_code_o & $past(evt_code_o)) == $past(evt_code_o)));

  p_ack_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !sw_enable_i) |=> (evt_code_o == 3'b000));

  p_suppress_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !ret_valid_i && st_suppress_i) |=> !irq_o);

  p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_o && !ret_valid_i && !st_valid_i) |=> !irq_o);
endmodule

bind dbg_event_watch dbg_event_watch_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ret_valid_i   (ret_valid_i),
  .st_valid_i    (st_valid_i),
  .st_suppress_i (st_suppress_i),
  .sw_enable_i   (sw_enable_i),
  .irq_ack_i     (irq_ack_i),
  .evt_code_o    (evt_code_o),
  .irq_o         (irq_o)
);

// File: tb/sim_dbg_event_watch.sv
`timescale 1ns/1ps
module sim_dbg_event_watch;
  localparam int unsigned AW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ret_valid_i = 1'b0, ret_br_taken_i = 1'b0;
  logic [AW-1:0] ret_addr_i = '0, ret_br_tgt_i = '0;
  logic          st_valid_i = 1'b0, st_suppress_i = 1'b0;
  logic [AW-1:0] st_addr_i = '0;
  logic [2:0]    ctl_mask_i = 3'b111;
  logic [AW-1:0] ctl_lo_i = 16'h1000, ctl_hi_i = 16'h1FFF;
  logic          sw_enable_i = 1'b1, irq_ack_i = 1'b0;
  logic [2:0]    evt_code_o;
  logic          irq_o;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbg_event_watch #(.AW(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .ret_valid_i(ret_valid_i), .ret_addr_i(ret_addr_i),
    .ret_br_taken_i(ret_br_taken_i), .ret_br_tgt_i(ret_br_tgt_i),
    .st_valid_i(st_valid_i), .st_addr_i(st_addr_i), .st_suppress_i(st_suppress_i),
    .ctl_mask_i(ctl_mask_i), .ctl_lo_i(ctl_lo_i), .ctl_hi_i(ctl_hi_i),
    .sw_enable_i(sw_enable_i), .irq_ack_i(irq_ack_i),
    .evt_code_o(evt_code_o), .irq_o(irq_o)
  );

  task automatic check(string req, logic [2:0] exp_code);
    n_vec++;
    if (evt_code_o !== exp_code || irq_o !== (exp_code != 3'b000)) begin
      n_bad++;
      $display("FAIL %s: code=%b irq=%b expected code=%b irq=%b",
               req, evt_code_o, irq_o, exp_code, exp_code != 3'b000);
    end
  endtask

  // one clock edge, then pulse inputs return to idle
  task automatic step();
    @(posedge clk);
    #1;
    ret_valid_i = 1'b0; ret_br_taken_i = 1'b0;
    st_valid_i = 1'b0; st_suppress_i = 1'b0; irq_ack_i = 1'b0;
  endtask

  task automatic clear();
    irq_ack_i = 1'b1;
    step();
  endtask

  task automatic retire(logic [AW-1:0] a, logic tk, logic [AW-1:0] t);
    ret_valid_i = 1'b1; ret_addr_i = a; ret_br_taken_i = tk; ret_br_tgt_i = t;
  endtask

  task automatic t_reset();
    check("R1 reset", 3'b000);
  endtask

  task automatic t_branch();
    clear(); retire(16'h0100, 1'b1, 16'h1800); step(); check("R2 taken branch", 3'b001);
    clear(); retire(16'h0100, 1'b0, 16'h1800); step(); check("R2 not taken", 3'b000);
  endtask

  task automatic t_fetch();
    clear(); retire(16'h1000, 1'b0, 16'h0); step(); check("R3 R5 fetch at lo", 3'b010);
    clear(); retire(16'h1FFF, 1'b0, 16'h0); step(); check("R5 fetch at hi", 3'b010);
    clear(); retire(16'h2000, 1'b0, 16'h0); step(); check("R5 above hi", 3'b000);
    clear(); retire(16'h0FFF, 1'b0, 16'h0); step(); check("R5 below lo", 3'b000);
  endtask

  task automatic t_store();
    clear(); st_valid_i = 1'b1; st_addr_i = 16'h1234; step(); check("R4 store", 3'b100);
    clear(); st_valid_i = 1'b1; st_addr_i = 16'h1234; st_suppress_i = 1'b1;
    step(); check("R4 suppressed store", 3'b000);
  endtask

  task automatic t_wrap();
    ctl_lo_i = 16'hF000; ctl_hi_i = 16'h0100;
    clear(); retire(16'hFFFF, 1'b0, 16'h0); step(); check("R6 wrap top", 3'b010);
    clear(); retire(16'h0000, 1'b0, 16'h0); step(); check("R6 wrap bottom", 3'b010);
    clear(); retire(16'h8000, 1'b0, 16'h0); step(); check("R6 wrap gap", 3'b000);
    ctl_lo_i = 16'h1000; ctl_hi_i = 16'h1FFF;
  endtask

  task automatic t_mask();
    ctl_mask_i = 3'b101;
    clear(); retire(16'h1100, 1'b0, 16'h0); step(); check("R7 fetch masked", 3'b000);
    ctl_mask_i = 3'b110;
    clear(); retire(16'h0100, 1'b1, 16'h1100); step(); check("R7 branch masked", 3'b000);
    ctl_mask_i = 3'b011;
    clear(); st_valid_i = 1'b1; st_addr_i = 16'h1100; step(); check("R7 store masked", 3'b000);
    ctl_mask_i = 3'b111;
  endtask

  task automatic t_enable();
    sw_enable_i = 1'b0;
    clear(); retire(16'h1100, 1'b1, 16'h1200); st_valid_i = 1'b1; st_addr_i = 16'h1300;
    step(); check("R8 disabled", 3'b000);
    sw_enable_i = 1'b1;
  endtask

  task automatic t_combo();
    clear(); retire(16'h1100, 1'b1, 16'h1200); st_valid_i = 1'b1; st_addr_i = 16'h1300;
    step(); check("R9 R11 merged", 3'b111);
  endtask

  task automatic t_hold();
    clear(); st_valid_i = 1'b1; st_addr_i = 16'h1300; step(); check("R10 first", 3'b100);
    retire(16'h1400, 1'b0, 16'h0); step(); check("R10 accumulate", 3'b110);
    step(); check("R10 hold idle", 3'b110);
    irq_ack_i = 1'b1; retire(16'h0100, 1'b1, 16'h1500); step(); check("R10 ack with hit", 3'b001);
    irq_ack_i = 1'b1; step(); check("R10 R11 ack clears", 3'b000);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #12;
    t_reset();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_branch();
    t_fetch();
    t_store();
    t_wrap();
    t_mask();
    t_enable();
    t_combo();
    t_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule